// File: doc/BRIEF.md
# Multi-mode packet frame encapsulator

This block is the transmit-side packet processor for one data channel. Packets enter one byte at a time on a valid/ready stream that marks the first and last byte. The block puts out one byte on every clock. The output is a continuous octet stream in which each packet sits between flag bytes of value 0x7E. When no packet is waiting, the stream carries flags only.

A two-bit mode input selects one of three encapsulations:

- Flag framing only.
- Flag framing plus a frame check sequence.
- A PPP-style header in front of the payload, plus the frame check sequence.

A separate control bit picks a 16-bit or 32-bit check. Any byte between flags that would look like a flag or an escape byte is replaced by a two-byte escape sequence. While the block emits bytes that do not come from the input, it holds ready low, so no input byte is lost. Mode, check width and protocol field are sampled once, at the start of each packet.

Top module: `pkt_encap`

## Requirements
- R1: After reset, and whenever no packet is in progress, the output is 0x7E on every cycle and in_ready_o is high.
- R2: Mode 2'b00 (and the unused code 2'b11) sends the payload between flags with no check word appended.
- R3: Mode 2'b01 with crc32_i low appends a 16-bit check. The check uses polynomial x^16+x^12+x^5+1, processed LSB-first with a preset of 0xFFFF. It is complemented and sent low byte first.
- R4: With crc32_i high, the check is the 32-bit Ethernet CRC (reflected polynomial 0xEDB88320, preset all ones, complemented). Its four bytes are sent low byte first.
- R5: Mode 2'b10 sends 0xFF, 0x03, proto_i[15:8], proto_i[7:0] before the payload. The check covers these header bytes. In the cycle a PPP start byte is offered in idle, in_ready_o is low.
- R6: Any header, payload or check byte equal to 0x7E or 0x7D is sent as 0x7D followed by the byte XOR 0x20.
- R7: in_ready_o is low while the second byte of an escape, a header byte, a check byte or the closing flag is being produced. Every accepted payload byte appears in the output exactly once and in order.
- R8: When a new packet starts right after another, a single 0x7E closes the first packet and opens the second.
- R9: mode_i, crc32_i and proto_i are sampled when the first byte is accepted. Changes to them later in the packet have no effect on that packet.
- R10: In idle, a valid byte without the start marker is accepted and dropped, and the output stays at 0x7E.
- R11: A packet whose first byte also carries the end marker is framed correctly in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 flag only, 01 check, 10 PPP header plus check |
| crc32_i | input | 1 | 1 selects 32-bit check, 0 selects 16-bit |
| proto_i | input | 16 | Protocol field for the PPP header |
| in_data_i | input | 8 | Payload byte |
| in_valid_i | input | 1 | Payload byte valid |
| in_sop_i | input | 1 | First byte of a packet |
| in_eop_i | input | 1 | Last byte of a packet |
| in_ready_o | output | 1 | Block accepts the offered byte this cycle |
| out_data_o | output | 8 | Output octet, one per clock |

## Verification
The main function is driven with packets that mix plain bytes with 0x7E and 0x7D values, across all three modes and both check widths. The escape and stall paths are therefore exercised from payload, header and check bytes alike. A packet made only of escapable bytes separates a correct hold on ready from one that drops or repeats input. Back-to-back packets of different modes show whether a single shared flag is used and whether per-packet sampling holds. A parameter swap in the middle of a packet, one-byte packets, and stray bytes offered in idle probe the sampling point, the start/end corner and the discard path. The check model is first confirmed against the well-known check values of the nine-byte ASCII string "123456789".

// File: rtl/pkt_encap_pkg.sv
package pkt_encap_pkg;
  typedef enum logic [1:0] {
    MODE_HDLC = 2'b00,
    MODE_CRC  = 2'b01,
    MODE_PPP  = 2'b10
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_FCS,
    ST_END
  } st_e;

  localparam logic [7:0] FLAG_BYTE = 8'h7E;
  localparam logic [7:0] ESC_BYTE  = 8'h7D;
  localparam logic [7:0] ESC_MASK  = 8'h20;
  localparam logic [7:0] HDR_ADDR  = 8'hFF;
  localparam logic [7:0] HDR_CTRL  = 8'h03;
  localparam logic [15:0] POLY16_REV = 16'h8408;
  localparam logic [31:0] POLY32_REV = 32'hEDB88320;
endpackage

// File: rtl/pkt_crc.sv
module pkt_crc #(
  parameter int         W    = 16,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         en_i,
  input  logic [7:0]   data_i,
  output logic [W-1:0] crc_o
);
  localparam int PAD = W - 8;

  function automatic logic [W-1:0] upd(logic [W-1:0] c, logic [7:0] d);
    logic [W-1:0] r;
    r = c ^ {{PAD{1'b0}}, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  logic [W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (en_i)   crc_q <= upd(init_i ? '1 : crc_q, data_i);
    else if (init_i) crc_q <= '1;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/pkt_encap.sv
module pkt_encap
  import pkt_encap_pkg::*;
#(
  parameter int PROTO_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic               crc32_i,
  input  logic [PROTO_W-1:0] proto_i,
  input  logic [7:0]         in_data_i,
  input  logic               in_valid_i,
  input  logic               in_sop_i,
  input  logic               in_eop_i,
  output logic               in_ready_o,
  output logic [7:0]         out_data_o
);
  localparam int IDX_W = 2;

  st_e                st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [7:0]         out_q, out_d;
  logic               esc_q, esc_d;
  logic [7:0]         escb_q, escb_d;
  logic [1:0]         mode_q, mode_d;
  logic               c32_q, c32_d;
  logic [PROTO_W-1:0] proto_q, proto_d;

  logic        crc_init, crc_en, raw_vld, ready, ppp_start, has_fcs;
  logic [7:0]  raw;
  logic [15:0] crc16;
  logic [31:0] crc32, fcs_word;
  logic [IDX_W-1:0] fcs_last;

  pkt_crc #(.W(16), .POLY(POLY16_REV)) u_crc16 (
    .clk_i, .rst_ni, .init_i(crc_init), .en_i(crc_en), .data_i(raw), .crc_o(crc16)
  );
  pkt_crc #(.W(32), .POLY(POLY32_REV)) u_crc32 (
    .clk_i, .rst_ni, .init_i(crc_init), .en_i(crc_en), .data_i(raw), .crc_o(crc32)
  );

  assign fcs_word  = c32_q ? ~crc32 : {16'h0000, ~crc16};
  assign fcs_last  = c32_q ? 2'd3 : 2'd1;
  assign has_fcs   = (mode_q == MODE_CRC) || (mode_q == MODE_PPP);
  assign ppp_start = in_valid_i && in_sop_i && (mode_i == MODE_PPP);

  always_comb begin
    st_d = st_q; idx_d = idx_q; esc_d = esc_q; escb_d = escb_q;
    mode_d = mode_q; c32_d = c32_q; proto_d = proto_q;
    ready = 1'b0; raw_vld = 1'b0; raw = 8'h00; crc_en = 1'b0; crc_init = 1'b0;
    out_d = FLAG_BYTE;
    if (esc_q) begin
      out_d = escb_q ^ ESC_MASK;
      esc_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          ready = !ppp_start;
          if (in_valid_i && in_sop_i) begin
            mode_d = mode_i; c32_d = crc32_i; proto_d = proto_i;
            crc_init = 1'b1; crc_en = 1'b1; raw_vld = 1'b1; idx_d = '0;
            if (ppp_start) begin
              raw = HDR_ADDR; st_d = ST_HDR; idx_d = 2'd1;
            end else begin
              raw  = in_data_i;
              st_d = !in_eop_i ? ST_DATA : (mode_i == MODE_CRC) ? ST_FCS : ST_END;
            end
          end
        end
        ST_HDR: begin
          raw_vld = 1'b1; crc_en = 1'b1;
          unique case (idx_q)
            2'd1:    raw = HDR_CTRL;
            2'd2:    raw = proto_q[PROTO_W-1 -: 8];
            default: raw = proto_q[7:0];
          endcase
          idx_d = idx_q + 1'b1;
          if (idx_q == 2'd3) st_d = ST_DATA;
        end
        ST_DATA: begin
          ready = 1'b1;
          if (in_valid_i) begin
            raw = in_data_i; raw_vld = 1'b1; crc_en = 1'b1; idx_d = '0;
            if (in_eop_i) st_d = has_fcs ? ST_FCS : ST_END;
          end
        end
        ST_FCS: begin
          raw = fcs_word[{idx_q, 3'b000} +: 8]; raw_vld = 1'b1;
          idx_d = idx_q + 1'b1;
          if (idx_q == fcs_last) st_d = ST_END;
        end
        ST_END:  st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
      if (raw_vld) begin
        if (raw == FLAG_BYTE || raw == ESC_BYTE) begin
          out_d = ESC_BYTE; esc_d = 1'b1; escb_d = raw;
        end else begin
          out_d = raw;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; idx_q <= '0; out_q <= FLAG_BYTE; esc_q <= 1'b0;
      escb_q <= '0; mode_q <= '0; c32_q <= 1'b0; proto_q <= '0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; out_q <= out_d; esc_q <= esc_d;
      escb_q <= escb_d; mode_q <= mode_d; c32_q <= c32_d; proto_q <= proto_d;
    end
  end

  assign in_ready_o = ready;
  assign out_data_o = out_q;

  AST_ESC_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_q |-> !in_ready_o); // R7
  AST_ESC_MARKER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_q |-> out_data_o == ESC_BYTE); // R6
  AST_IDLE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !esc_q) |-> out_data_o == FLAG_BYTE); // R1
  AST_HDR_ONLY_PPP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_HDR |-> mode_q == MODE_PPP); // R5
  AST_NO_FCS_FLAGONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_FCS |-> (mode_q == MODE_CRC || mode_q == MODE_PPP)); // R2
  AST_FCS_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_FCS |-> idx_q <= (c32_q ? 2'd3 : 2'd1)); // R4
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> ($stable(mode_q) && $stable(c32_q))); // R9
endmodule

// File: tb/sim_pkt_encap.sv
`timescale 1ns/1ps
module sim_pkt_encap;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_ni, crc32_i, in_valid_i, in_sop_i, in_eop_i, in_ready_o;
  logic [1:0]  mode_i;
  logic [15:0] proto_i;
  logic [7:0]  in_data_i, out_data_o;

  pkt_encap u0 (
    .clk_i(clk), .rst_ni, .mode_i, .crc32_i, .proto_i, .in_data_i,
    .in_valid_i, .in_sop_i, .in_eop_i, .in_ready_o, .out_data_o
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  logic [7:0] exp_q[$];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(logic [7:0] b[$], bit w32);
    logic [31:0] c, p;
    c = w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    p = w32 ? 32'hEDB8_8320 : 32'h0000_8408;
    foreach (b[i]) begin
      c ^= {24'h0, b[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
    end
    return w32 ? ~c : (~c & 32'h0000_FFFF);
  endfunction

  task automatic push_frame(logic [7:0] pl[$], logic [1:0] m, bit w32, logic [15:0] pr);
    logic [7:0] body[$];
    logic [31:0] f;
    if (m == 2'b10) body = {8'hFF, 8'h03, pr[15:8], pr[7:0]};
    foreach (pl[i]) body.push_back(pl[i]);
    if (m == 2'b01 || m == 2'b10) begin
      f = ref_crc(body, w32);
      for (int k = 0; k < (w32 ? 4 : 2); k++) body.push_back(f[8*k +: 8]);
    end
    foreach (body[i]) begin
      if (body[i] == 8'h7E || body[i] == 8'h7D) begin
        exp_q.push_back(8'h7D); exp_q.push_back(body[i] ^ 8'h20);
      end else exp_q.push_back(body[i]);
    end
    exp_q.push_back(8'h7E);
  endtask

  // one clock: compare the output to the model at the falling edge
  task automatic cycle();
    logic [7:0] e;
    @(negedge clk);
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h7E;
    chk(out_data_o == e, cur_req, {24'h0, out_data_o}, {24'h0, e});
    if (out_data_o == 8'h7D)
      chk(in_ready_o == 1'b0, "R7 ready during escape", {31'h0, in_ready_o}, 0);
  endtask

  task automatic send(logic [7:0] pl[$], logic [1:0] m, bit w32, logic [15:0] pr, bit flip);
    bit rdy;
    mode_i = m; crc32_i = w32; proto_i = pr;
    push_frame(pl, m, w32, pr);
    for (int i = 0; i < pl.size(); i++) begin
      in_valid_i = 1'b1; in_sop_i = (i == 0); in_eop_i = (i == pl.size() - 1);
      in_data_i = pl[i];
      #1 rdy = in_ready_o;
      if (i == 0 && m == 2'b10)
        chk(rdy == 1'b0, "R5 ready low on PPP start", {31'h0, rdy}, 0);
      while (!rdy) begin
        cycle();
        #1 rdy = in_ready_o;
      end
      cycle();
      if (flip && i == 0) begin
        mode_i = ~m; crc32_i = ~w32; proto_i = ~pr;
      end
    end
    in_valid_i = 1'b0; in_sop_i = 1'b0; in_eop_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) cycle();
    repeat (3) cycle();
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog expired act=0 exp=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; mode_i = 2'b00; crc32_i = 1'b0; proto_i = 16'h0;
    in_valid_i = 1'b0; in_sop_i = 1'b0; in_eop_i = 1'b0; in_data_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(out_data_o == 8'h7E, "R1 reset flag", {24'h0, out_data_o}, 32'h7E);
    chk(in_ready_o == 1'b1, "R1 reset ready", {31'h0, in_ready_o}, 1);
    cur_req = "R1 idle fill";
    repeat (4) cycle();

    chk(ref_crc({8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39}, 1'b0) == 32'h906E,
        "R3 model check value", ref_crc({8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39}, 1'b0), 32'h906E);
    chk(ref_crc({8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39}, 1'b1) == 32'hCBF43926,
        "R4 model check value", ref_crc({8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39}, 1'b1), 32'hCBF43926);

    cur_req = "R2 R6 flag-only with escapes";
    send({8'h11, 8'h7E, 8'h22, 8'h7D, 8'h33}, 2'b00, 1'b0, 16'h0, 1'b0); drain();
    cur_req = "R2 unused mode code";
    send({8'h44, 8'h55}, 2'b11, 1'b1, 16'h0, 1'b0); drain();
    cur_req = "R3 16-bit check";
    send({8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39}, 2'b01, 1'b0, 16'h0, 1'b0); drain();
    cur_req = "R4 32-bit check";
    send({8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39}, 2'b01, 1'b1, 16'h0, 1'b0); drain();
    cur_req = "R5 PPP header 16-bit";
    send({8'h45, 8'h00, 8'h7E, 8'h01}, 2'b10, 1'b0, 16'h0021, 1'b0); drain();
    cur_req = "R6 PPP header escapes";
    send({8'hA5, 8'h5A}, 2'b10, 1'b1, 16'h7E7D, 1'b0); drain();
    cur_req = "R7 all-escape payload";
    send({8'h7E, 8'h7E, 8'h7D, 8'h7D, 8'h7E}, 2'b01, 1'b1, 16'h0, 1'b0); drain();
    cur_req = "R8 back-to-back shared flag";
    send({8'h01, 8'h02, 8'h03}, 2'b01, 1'b0, 16'h0, 1'b0);
    send({8'h7D, 8'h04}, 2'b00, 1'b0, 16'h0, 1'b0);
    send({8'h05, 8'h06}, 2'b10, 1'b1, 16'hC021, 1'b0);
    send({8'h07}, 2'b01, 1'b1, 16'h0, 1'b0); drain();
    cur_req = "R9 mid-packet parameter change";
    send({8'h10, 8'h20, 8'h30, 8'h40, 8'h50}, 2'b10, 1'b0, 16'h8021, 1'b1); drain();
    send({8'h61, 8'h62, 8'h63}, 2'b00, 1'b1, 16'h0, 1'b1); drain();
    cur_req = "R11 single-byte packets";
    send({8'h7D}, 2'b01, 1'b1, 16'h0, 1'b0); drain();
    send({8'hAA}, 2'b00, 1'b0, 16'h0, 1'b0); drain();
    send({8'h7E}, 2'b10, 1'b0, 16'h0057, 1'b0); drain();

    cur_req = "R10 stray byte dropped";
    for (int i = 0; i < 3; i++) begin
      in_valid_i = 1'b1; in_sop_i = 1'b0; in_eop_i = (i == 2); in_data_i = 8'h7E ^ 8'(i);
      #1 chk(in_ready_o == 1'b1, "R10 ready for stray byte", {31'h0, in_ready_o}, 1);
      cycle();
    end
    in_valid_i = 1'b0; in_eop_i = 1'b0;
    repeat (4) cycle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule